// File: doc/BRIEF.md
# FIFO Trigger-Level Interrupt Generator

This block raises the receive and transmit FIFO interrupt requests of one serial channel. Each cycle it compares the occupancy counts of a 16-entry receive FIFO and a 16-entry transmit FIFO against a trigger level. It drives one request line per direction to the channel's interrupt prioritizer. The FIFOs, the receive time-out and any DMA signalling sit outside the block.

The trigger level comes from a write-only control byte. Bits 7:6 carry a receive selection code and bits 5:4 carry a transmit selection code. Both directions share a single table entry: whichever field a write actually changed becomes the code for both sides. The transmit side remembers whether its count rose above the trigger after the FIFO was last empty. If it did, the request fires once the count drops below the trigger. If it did not, the request waits until the FIFO is empty. When the FIFOs are switched off, both sides use a trigger of one character.

Top module: `fifo_trig_irq`

## Requirements
- R1: While reset is held, both requests are low. After reset the shared code is 00, and the stored copies of both fields are 00.
- R2: Selection codes 00, 01, 10 and 11 give trigger levels of 1, 4, 8 and 14 characters.
- R3: With FIFOs enabled, rx_req is high in the cycle after the receive count is at or above the trigger level, and low in the cycle after it is below the trigger level.
- R4: Once the transmit count has exceeded the trigger level since the transmit FIFO was last empty, tx_req is high in the cycle after the count is below the trigger level, and low otherwise.
- R5: If the transmit count has not exceeded the trigger level since the FIFO was last empty, tx_req is high only in the cycle after the count is zero.
- R6: A write (wr_en high) whose bits 7:6 differ from the previous write's bits 7:6 loads those bits as the shared code. A write that changes only bits 5:4 loads bits 5:4. A write that changes neither leaves the code unchanged. When a write changes both, bits 7:6 win. A new code affects the requests two cycles after the write.
- R7: With fifo_en low, both directions use a trigger of 1. The stored code is kept and applies again once fifo_en returns high.
- R8: Control data presented while wr_en is low has no effect on the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte; bits 7:6 receive code, bits 5:4 transmit code |
| fifo_en | input | 1 | FIFOs enabled |
| rx_cnt | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_cnt | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_req | output | 1 | Receive trigger request |
| tx_req | output | 1 | Transmit trigger request |

## Verification
A count change shows on its request one clock edge later, because each request is a single register fed by the current count. A control write takes two edges to show: one to load the shared code and one to register the comparison. The bench applies every input just after a falling edge and updates its reference model at the next rising edge. It then compares both requests at the falling edge that follows. For every write, the reference model holds the new code back until after it has evaluated the requests of the write cycle, so each expected value is due in exactly the cycle the requirements name.

// File: rtl/fti_pkg.sv
package fti_pkg;
   localparam int CODE_W = 2;
   localparam int N_CODES = 1 << CODE_W;
   typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/fti_level_sel.sv
module fti_level_sel
   import fti_pkg::*;
#(
   parameter int CNT_W   = 5,
   parameter int CTRL_W  = 8,
   parameter int RX_LSB  = 6,
   parameter int TX_LSB  = 4,
   parameter int LVL_C0  = 1,
   parameter int LVL_C1  = 4,
   parameter int LVL_C2  = 8,
   parameter int LVL_C3  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              fifo_en,
   output logic [CNT_W-1:0]  level
);
   localparam int LVLS [N_CODES] = '{LVL_C0, LVL_C1, LVL_C2, LVL_C3};

   code_t rx_fld, tx_fld;
   code_t rx_shadow_q, tx_shadow_q, code_q;
   logic [CNT_W-1:0] table_lvl [N_CODES];

   assign rx_fld = wr_data[RX_LSB +: CODE_W];
   assign tx_fld = wr_data[TX_LSB +: CODE_W];

   // Level table built from the parameters
   for (genvar g = 0; g < N_CODES; g++) begin : g_tbl
      assign table_lvl[g] = CNT_W'(LVLS[g]);
   end

   // The field that changed most recently selects the shared code
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_shadow_q <= '0;
         tx_shadow_q <= '0;
         code_q      <= '0;
      end else if (wr_en) begin
         rx_shadow_q <= rx_fld;
         tx_shadow_q <= tx_fld;
         if (rx_fld != rx_shadow_q)
            code_q <= rx_fld;
         else if (tx_fld != tx_shadow_q)
            code_q <= tx_fld;
      end
   end

   assign level = fifo_en ? table_lvl[code_q] : CNT_W'(1);
endmodule

// File: rtl/fti_rx_cmp.sv
module fti_rx_cmp #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] level,
   output logic             req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= 1'b0;
      else        req <= (cnt >= level);
   end
endmodule

// File: rtl/fti_tx_track.sv
module fti_tx_track #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] level,
   output logic             req
);
   logic over_q;
   logic req_d;

   // Select the falling-below rule or the empty rule
   always_comb begin
      if (over_q) req_d = (cnt < level);
      else        req_d = (cnt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         over_q <= 1'b0;
         req    <= 1'b0;
      end else begin
         req <= req_d;
         if (cnt == '0)
            over_q <= 1'b0;
         else if (cnt > level)
            over_q <= 1'b1;
      end
   end
endmodule

// File: rtl/fifo_trig_irq.sv
module fifo_trig_irq
   import fti_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int CTRL_W  = 8,
   parameter int RX_LSB  = 6,
   parameter int TX_LSB  = 4,
   parameter int LVL_C0  = 1,
   parameter int LVL_C1  = 4,
   parameter int LVL_C2  = 8,
   parameter int LVL_C3  = 14,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              fifo_en,
   input  logic [CNT_W-1:0]  rx_cnt,
   input  logic [CNT_W-1:0]  tx_cnt,
   output logic              rx_req,
   output logic              tx_req
);
   // Elaboration-time parameter checks
   if (DEPTH < 2)
      $error("DEPTH must be at least 2");
   if (RX_LSB + CODE_W > CTRL_W || TX_LSB + CODE_W > CTRL_W)
      $error("selection field outside control byte");
   if (LVL_C0 < 1 || LVL_C1 < 1 || LVL_C2 < 1 || LVL_C3 < 1)
      $error("trigger levels must be at least 1");
   if (LVL_C0 > DEPTH || LVL_C1 > DEPTH || LVL_C2 > DEPTH || LVL_C3 > DEPTH)
      $error("trigger levels must not exceed DEPTH");

   logic [CNT_W-1:0] level;

   fti_level_sel #(
      .CNT_W(CNT_W), .CTRL_W(CTRL_W), .RX_LSB(RX_LSB), .TX_LSB(TX_LSB),
      .LVL_C0(LVL_C0), .LVL_C1(LVL_C1), .LVL_C2(LVL_C2), .LVL_C3(LVL_C3)
   ) u_sel (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .fifo_en(fifo_en), .level(level)
   );

   fti_rx_cmp #(.CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .cnt(rx_cnt), .level(level), .req(rx_req)
   );

   fti_tx_track #(.CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .cnt(tx_cnt), .level(level), .req(tx_req)
   );
endmodule

// File: rtl/fti_checker.sv
module fti_checker #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_en,
   input logic [CNT_W-1:0] rx_cnt,
   input logic [CNT_W-1:0] tx_cnt,
   input logic             rx_req,
   input logic             tx_req
);
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (!rx_req && !tx_req));

   a_r3_empty_rx_low: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == '0) |=> !rx_req);

   a_r3_full_rx_high: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == CNT_W'(DEPTH)) |=> rx_req);

   a_r5_empty_tx_high: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt == '0) |=> tx_req);

   a_r4_full_tx_low: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt == CNT_W'(DEPTH)) |=> !tx_req);

   a_r7_disabled_rx_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && rx_cnt != '0) |=> rx_req);
endmodule

bind fifo_trig_irq fti_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_cnt(rx_cnt),
   .tx_cnt(tx_cnt), .rx_req(rx_req), .tx_req(tx_req)
);

// File: tb/tb_fifo_trig_irq.sv
`timescale 1ns/1ps
module tb_fifo_trig_irq;
   localparam int DEPTH = 16;
   localparam int CW = 5;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, fifo_en = 1'b1;
   logic [7:0] wr_data = '0;
   logic [CW-1:0] rx_cnt = '0, tx_cnt = '0;
   logic rx_req, tx_req;

   int n_chk = 0, n_fail = 0;
   logic [1:0] m_code = '0, m_rxsh = '0, m_txsh = '0;
   bit m_over = 0, e_rx, e_tx, used_over;

   fifo_trig_irq dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .fifo_en(fifo_en), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
      .rx_req(rx_req), .tx_req(tx_req)
   );

   always #2.5 clk = ~clk;

   function automatic int lvl_of(logic [1:0] c, bit en);
      if (!en) return 1;
      case (c)
         2'd0: return 1;
         2'd1: return 4;
         2'd2: return 8;
         default: return 14;
      endcase
   endfunction

   task automatic check(logic act, logic exp, string tag, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // One cycle: model update at the rising edge, compare at the falling edge
   task automatic step();
      int l;
      @(posedge clk);
      l = lvl_of(m_code, fifo_en);
      e_rx = (int'(rx_cnt) >= l);
      used_over = m_over;
      e_tx = m_over ? (int'(tx_cnt) < l) : (tx_cnt == 0);
      if (tx_cnt == 0) m_over = 0;
      else if (int'(tx_cnt) > l) m_over = 1;
      if (wr_en) begin
         if (wr_data[7:6] != m_rxsh) m_code = wr_data[7:6];
         else if (wr_data[5:4] != m_txsh) m_code = wr_data[5:4];
         m_rxsh = wr_data[7:6];
         m_txsh = wr_data[5:4];
      end
      @(negedge clk);
      check(rx_req, e_rx, fifo_en ? "R3" : "R7", "rx_req model");
      check(tx_req, e_tx, fifo_en ? (used_over ? "R4" : "R5") : "R7", "tx_req model");
   endtask

   task automatic wr(logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   // Look for the rx trigger edge at level l
   task automatic probe(int l, string tag);
      rx_cnt = CW'(l - 1); step(); check(rx_req, 1'b0, tag, "below level");
      rx_cnt = CW'(l);     step(); check(rx_req, 1'b1, tag, "at level");
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (2) @(negedge clk);
      check(rx_req, 1'b0, "R1", "rx in reset");
      check(tx_req, 1'b0, "R1", "tx in reset");
      rst_n = 1'b1;
      step();
      check(tx_req, 1'b1, "R5", "empty tx after reset");
      probe(1, "R1");

      // R2: each code in turn, the rx field changes every time
      for (int c = 1; c < 4; c++) begin
         wr({c[1:0], c[1:0], 4'b0});
         step();
         probe(lvl_of(c[1:0], 1'b1), "R2");
      end

      // R6: shadows now 11/11
      wr(8'b11_01_0000); step(); probe(4, "R6");
      wr(8'b10_01_0000); step(); probe(8, "R6");
      wr(8'b10_01_0000); step(); probe(8, "R6");
      wr(8'b00_11_0000); step(); probe(1, "R6");

      // R8: data without strobe
      wr_data = 8'b11_11_0000;
      repeat (3) step();
      probe(1, "R8");

      // R7: code 11 kept while disabled
      wr(8'b11_11_0000); step();
      fifo_en = 1'b0; step(); probe(1, "R7");
      fifo_en = 1'b1; step(); probe(14, "R7");

      // R4/R5: level 4
      wr(8'b01_01_0000); step();
      tx_cnt = 0; step();
      tx_cnt = 3; step(); check(tx_req, 1'b0, "R5", "partial reload");
      tx_cnt = 2; step(); check(tx_req, 1'b0, "R5", "partial drain");
      tx_cnt = 0; step(); check(tx_req, 1'b1, "R5", "drained empty");
      tx_cnt = 10; step(); check(tx_req, 1'b0, "R4", "filled over");
      tx_cnt = 5; step(); check(tx_req, 1'b0, "R4", "above level");
      tx_cnt = 3; step(); check(tx_req, 1'b1, "R4", "fell below");

      // Random walk on counts with occasional writes
      for (int i = 0; i < 4000; i++) begin
         int r, t;
         r = int'(rx_cnt) + int'($urandom_range(6)) - 3;
         t = int'(tx_cnt) + int'($urandom_range(6)) - 3;
         if (r < 0) r = 0;
         if (r > DEPTH) r = DEPTH;
         if (t < 0) t = 0;
         if (t > DEPTH) t = DEPTH;
         rx_cnt = CW'(r);
         tx_cnt = CW'(t);
         fifo_en = ($urandom_range(15) != 0);
         wr_data = 8'($urandom);
         wr_en = ($urandom_range(20) == 0);
         step();
      end
      wr_en = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule